// File: doc/BRIEF.md
# Transmit Audio Sample Conditioner

This block sits between a show-ahead PCM sample FIFO and a multi-channel serial frame formatter, such as a TDM or I2S style transmitter. For each channel slot the formatter asks for, the block decides whether to take a word from the FIFO. It also picks the value to send, which is one of three things: the FIFO word, a constant zero, or the last value sent on that channel.

Software sets four control bits through a single 32-bit word. Mute silences the output but still drains one FIFO word per slot. Freeze stops the FIFO from being read and sends zero or the last sample. Active turns the transmitter on or off. Replay selects between zero and the last sample whenever freeze or an underflow calls for a substitute value. Mute and freeze are captured only on the slot flagged as the first channel of a frame. This means a frame is never partly muted, and channel data never shifts to another slot. An underflow that happens while active is recorded in a sticky flag that is cleared by a pulse.

Top module: `tx_sample_cond`

## Requirements
- R1: After reset the control word reads 0, and `sample_out`, `sample_valid`, `fifo_pop` and `underflow_flag` are all 0.
- R2: A write through `cfg_we` updates four control bits: mute at bit 16, freeze at bit 17, active at bit 18 and replay at bit 19. `cfg_rdata` returns those four bits in place and returns 0 in every other bit.
- R3: While active is 0, a slot request never pops the FIFO, sends zero and never sets `underflow_flag`.
- R4: With active set, no mute or freeze, and the FIFO not empty, a slot request pops once in the same cycle. In the next cycle, `sample_out` holds that FIFO word and `sample_valid` is 1.
- R5: In a muted frame, every slot sends zero and pops one word if the FIFO is not empty.
- R6: In a frozen frame, the FIFO is never popped, and the block sends zero when replay is 0.
- R7: In a frozen frame with replay 1, each slot sends the last value sent on the same channel position. The position counts from 0 at the slot flagged first.
- R8: A change to mute or freeze written in the middle of a frame has no effect until the next slot flagged as first.
- R9: On a slot that needs FIFO data while the FIFO is empty, the block sends zero when replay is 0, or the last value sent on that channel when replay is 1.
- R10: An underflow while active sets `underflow_flag`, which stays set until a pulse on `underflow_clr`. A new underflow in the same cycle as the clear pulse leaves the flag set.
- R11: When both mute and freeze are captured for a frame, mute wins: the block sends zero and pops the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | DW | FIFO head word (show-ahead) |
| fifo_pop | output | 1 | Pop the FIFO head this cycle |
| slot_req | input | 1 | Formatter asks for one channel sample |
| slot_first | input | 1 | Requested slot is channel 0 of a frame |
| sample_out | output | DW | Sample for the last requested slot |
| sample_valid | output | 1 | `sample_out` was updated by the previous cycle's request |
| underflow_clr | input | 1 | Clear pulse for the underflow flag |
| underflow_flag | output | 1 | Sticky underflow cause |

## Verification
The slot sequence is driven under each control combination in turn: inactive, normal, frozen with replay, frozen with zero, muted, and mute plus freeze. The FIFO pop count tells mute apart from freeze, since both send zero. Control writes placed between the first and second slot of a frame show whether the new setting leaks into the current frame. Empty-FIFO slots are driven with replay on and off, with the transmitter off, and together with a clear pulse. These cases separate the substituted value from the flag's set, clear and priority behaviour.

// File: rtl/tx_sample_cond.sv
module tx_sample_cond #(
  parameter int DW  = 16,
  parameter int NCH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  input  logic          slot_req,
  input  logic          slot_first,
  output logic [DW-1:0] sample_out,
  output logic          sample_valid,
  input  logic          underflow_clr,
  output logic          underflow_flag
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  logic          c_mute, c_freeze, c_active, c_replay;
  logic          sh_mute, sh_freeze;
  logic [CW-1:0] chan_q, cur_ch;
  logic [DW-1:0] hist [NCH];
  logic          use_mute, use_freeze, want_pop, underrun;
  logic [DW-1:0] prev, next_sample;

  assign cfg_rdata = {12'd0, c_replay, c_active, c_freeze, c_mute, 16'd0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {c_replay, c_active, c_freeze, c_mute} <= '0;
    else if (cfg_we) {c_replay, c_active, c_freeze, c_mute} <= cfg_wdata[19:16];

  assign use_mute   = slot_first ? c_mute   : sh_mute;
  assign use_freeze = slot_first ? c_freeze : sh_freeze;
  assign cur_ch     = slot_first ? '0 : ((chan_q == LAST_CH) ? '0 : chan_q + 1'b1);
  assign want_pop   = slot_req & c_active & (use_mute | ~use_freeze);
  assign fifo_pop   = want_pop & ~fifo_empty;
  assign underrun   = want_pop & fifo_empty;
  assign prev       = hist[cur_ch];

  always_comb begin
    if (!c_active || use_mute)      next_sample = '0;
    else if (use_freeze || fifo_empty) next_sample = c_replay ? prev : '0;
    else                            next_sample = fifo_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_mute <= 1'b0; sh_freeze <= 1'b0; chan_q <= '0;
      sample_out <= '0; sample_valid <= 1'b0; underflow_flag <= 1'b0;
      for (int i = 0; i < NCH; i++) hist[i] <= '0;
    end else begin
      sample_valid <= slot_req;
      if (slot_req && slot_first) begin
        sh_mute   <= c_mute;
        sh_freeze <= c_freeze;
      end
      if (slot_req) begin
        chan_q       <= cur_ch;
        sample_out   <= next_sample;
        hist[cur_ch] <= next_sample;
      end
      if (underrun)           underflow_flag <= 1'b1;
      else if (underflow_clr) underflow_flag <= 1'b0;
    end

  assert_no_pop_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !c_active |-> !fifo_pop);
  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);
  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && use_mute) |=> (sample_out == '0));
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_first && sh_freeze && !sh_mute) |-> !fifo_pop);
  assert_flag_needs_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_flag) |-> $past(c_active));
  assert_mute_pops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && c_active && use_mute && !fifo_empty) |-> fifo_pop);
endmodule

// File: tb/tx_sample_cond_test.sv
module tx_sample_cond_test;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, slot_req = 0, slot_first = 0, underflow_clr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic fifo_empty, fifo_pop, sample_valid, underflow_flag;
  logic [DW-1:0] fifo_data, sample_out;
  logic [DW-1:0] mem [64];
  int rd = 0, wr = 0, checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign fifo_empty = (rd == wr);
  assign fifo_data  = mem[rd % 64];
  always @(posedge clk) if (fifo_pop) rd <= rd + 1;

  tx_sample_cond uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [DW-1:0] v);
    mem[wr % 64] = v; wr++;
  endtask

  task automatic set_cfg(bit m, bit f, bit a, bit r);
    @(negedge clk); cfg_we = 1; cfg_wdata = {12'hFFF, r, a, f, m, 16'hFFFF};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic slot(string tag, bit first, logic [DW-1:0] exp, bit exp_pop, bit clr = 0);
    int rd0;
    @(negedge clk);
    slot_req = 1; slot_first = first; underflow_clr = clr; rd0 = rd;
    #1 chk({tag, " pop"}, fifo_pop, exp_pop);
    @(negedge clk);
    slot_req = 0; slot_first = 0; underflow_clr = 0;
    chk({tag, " value"}, sample_out, exp);
    chk({tag, " valid"}, sample_valid, 1);
    chk({tag, " popcount"}, rd - rd0, exp_pop);
  endtask

  task automatic clear_flag();
    @(negedge clk); underflow_clr = 1;
    @(negedge clk); underflow_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 sample", sample_out, 0);
    chk("R1 valid", sample_valid, 0);
    chk("R1 pop", fifo_pop, 0);
    chk("R1 flag", underflow_flag, 0);
  endtask

  task automatic t_regs();
    set_cfg(1, 1, 1, 1);
    chk("R2 readback", cfg_rdata, 32'h000F0000);
    set_cfg(0, 0, 0, 0);
    chk("R2 cleared", cfg_rdata, 0);
  endtask

  task automatic t_inactive();
    push(16'h1111);
    slot("R3 inactive", 1, 0, 0);
    chk("R3 flag", underflow_flag, 0);
  endtask

  task automatic t_normal();
    set_cfg(0, 0, 1, 0);
    push(16'h2222);
    slot("R4 ch0", 1, 16'h1111, 1);
    slot("R4 ch1", 0, 16'h2222, 1);
  endtask

  task automatic t_freeze();
    set_cfg(0, 1, 1, 1);
    push(16'h3333);
    slot("R7 replay ch0", 1, 16'h1111, 0);
    slot("R7 replay ch1", 0, 16'h2222, 0);
    set_cfg(0, 1, 1, 0);
    slot("R6 zero ch0", 1, 0, 0);
    slot("R6 zero ch1", 0, 0, 0);
  endtask

  task automatic t_align();
    slot("R8 frozen ch0", 1, 0, 0);
    set_cfg(0, 0, 1, 0);
    slot("R8 still frozen ch1", 0, 0, 0);
    slot("R8 unfrozen ch0", 1, 16'h3333, 1);
    set_cfg(1, 0, 1, 0);
    push(16'h4444);
    slot("R8 mute deferred ch1", 0, 16'h4444, 1);
    push(16'h5555);
    slot("R5 muted ch0", 1, 0, 1);
  endtask

  task automatic t_priority();
    set_cfg(1, 1, 1, 1);
    push(16'h6666);
    slot("R11 mute over freeze", 1, 0, 1);
  endtask

  task automatic t_underflow();
    set_cfg(0, 0, 1, 1);
    push(16'h7777);
    slot("R9 prime", 1, 16'h7777, 1);
    chk("R10 no flag yet", underflow_flag, 0);
    slot("R9 replay on empty", 1, 16'h7777, 0);
    chk("R10 flag set", underflow_flag, 1);
    clear_flag();
    chk("R10 flag cleared", underflow_flag, 0);
    set_cfg(0, 0, 1, 0);
    slot("R9 zero on empty", 1, 0, 0);
    chk("R10 flag again", underflow_flag, 1);
    slot("R10 set beats clear", 1, 0, 0, 1);
    chk("R10 set beats clear flag", underflow_flag, 1);
    clear_flag();
    set_cfg(0, 0, 0, 1);
    slot("R3 inactive empty", 1, 0, 0);
    chk("R3 no flag when off", underflow_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_regs();
    t_inactive();
    t_normal();
    t_freeze();
    t_align();
    t_priority();
    t_underflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule